// File: doc/BRIEF.md
# Fault Outcome Monitor

This block watches a fault-injection run alongside a fault-free copy of the same run. It compares the two bus streams one bus cycle at a time and reacts to the two exception flags of the faulty run: invalid address and invalid opcode fetch. When the run finishes it issues one verdict. A run finishes either when an exception halts it or when the environment signals the end of the run.

Bus cycles are numbered from zero, starting at the first bus cycle after `run_start`. The monitor stamps three events with that number: the injection, the first bus mismatch and the detecting exception. An exception halts the run at once, and the monitor reports the latency as the detection cycle minus the injection cycle. At the end of the run the environment states whether any memory cell or register still differs from the reference, and the monitor uses that flag as well. The verdict is one of four classes, resolved in a fixed priority order. The exception type is reported in its own field.

Top module: `fault_outcome_monitor`

## Requirements
- R1: After reset, `res_valid` is 0, `res_class` is 0, `res_exc` is 0 and `run_active` is 0.
- R2: `run_start` clears all run state and sets `run_active`. The bus cycle number is 0 for the first bus cycle after start and increases by one per bus cycle. The injection stamp and the mismatch stamp are the number of the bus cycle in which the event is seen.
- R3: An exception seen during a bus cycle of an active run ends the run in that cycle. `res_class` becomes 3 (hardware-detected). `res_exc` becomes 1 for invalid address and 2 for invalid opcode, and invalid address wins when both flags are set. Until the next `run_start`, no input changes any output.
- R4: For a hardware-detected run, `res_latency` equals the detection cycle minus the injection cycle. It is 0 when no injection was seen before or in the detection cycle, and 0 for every other class.
- R5: A run with no exception is classed 2 (bus-active) if any of its bus cycles carried `obs_bus` different from `ref_bus`. This holds whatever the value of `store_diff`.
- R6: A run with no exception and no bus mismatch is classed 1 (latent) when `store_diff` is 1 in the `run_end` cycle.
- R7: A run with no exception, no bus mismatch and `store_diff` at 0 is classed 0 (no error), with `res_exc` 0.
- R8: `res_diff_seen` reports whether any mismatch occurred. `res_first_diff` gives the number of the first mismatching bus cycle, and later mismatches do not move it. It is 0 when no mismatch occurred.
- R9: When an exception and a bus mismatch fall in the same bus cycle, the run is hardware-detected, and that cycle is reported as the first mismatch if none came earlier.
- R10: Exception flags and bus values are ignored when `bus_cyc` is 0.
- R11: `res_valid` is a one-cycle pulse in the clock cycle after the finishing event. `run_end` has no effect when no run is active.
- R12: The bus cycle number saturates at 2^CYC_W-1, and stamps and latency use the saturated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_start | input | 1 | Begin a new run, clears run state |
| inj_pulse | input | 1 | Fault injected in this cycle |
| bus_cyc | input | 1 | A bus cycle completes in this clock |
| ref_bus | input | BUS_W | Bus value of the fault-free run |
| obs_bus | input | BUS_W | Bus value of the faulty run |
| exc_berr | input | 1 | Invalid-address exception in the faulty run |
| exc_illeg | input | 1 | Invalid-opcode exception in the faulty run |
| run_end | input | 1 | Run reached its end without halting |
| store_diff | input | 1 | Storage differs from reference at run end |
| run_active | output | 1 | A run is in progress |
| res_valid | output | 1 | Verdict pulse |
| res_class | output | 3 | 0 none, 1 latent, 2 bus-active, 3 hardware-detected |
| res_exc | output | 2 | 0 none, 1 invalid address, 2 invalid opcode |
| res_latency | output | CYC_W | Detection cycle minus injection cycle |
| res_diff_seen | output | 1 | At least one bus mismatch occurred |
| res_first_diff | output | CYC_W | Bus cycle number of the first mismatch |

## Verification
Two pairs of events can land in the same bus cycle. An exception can coincide with a bus mismatch. An exception can also coincide with the injection or with `run_end`. The sweep places the mismatch and the injection before, on and after every exception cycle, for each of the three exception flag combinations. For every verdict the bench recomputes the class, the exception type, the first-mismatch cycle and the latency from the positions it chose. Separate runs check that flags outside a bus cycle, and all inputs after a halt, leave the outputs unchanged.

// File: rtl/fom_pkg.sv
package fom_pkg;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_LATENT = 3'd1,
        CLS_BUSACT = 3'd2,
        CLS_HWDET  = 3'd3
    } fom_class_e;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_BERR  = 2'd1,
        EXC_ILLEG = 2'd2
    } fom_exc_e;

    localparam int unsigned FOM_NUM_EVT = 2;
    localparam int unsigned FOM_EVT_INJ = 0;
    localparam int unsigned FOM_EVT_DIF = 1;

endpackage

// File: rtl/fom_cycle_counter.sv
module fom_cycle_counter #(
    parameter int unsigned CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bus_cyc,
    input  logic             finish,
    output logic             active,
    output logic [CYC_W-1:0] count
);
    localparam logic [CYC_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             active;
        logic [CYC_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (start) begin
            ctr_d.active = 1'b1;
            ctr_d.cnt    = '0;
        end else if (ctr_q.active) begin
            if (bus_cyc && ctr_q.cnt != CNT_MAX) begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
            if (finish) begin
                ctr_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign active = ctr_q.active;
    assign count  = ctr_q.cnt;

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.active && !start && bus_cyc && ctr_q.cnt != CNT_MAX)
        |=> (ctr_q.cnt == $past(ctr_q.cnt) + 1'b1));

    p_sat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.active && !start && ctr_q.cnt == CNT_MAX) |=> (ctr_q.cnt == CNT_MAX));

endmodule

// File: rtl/fom_first_event.sv
module fom_first_event #(
    parameter int unsigned CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hit,
    input  logic [CYC_W-1:0] stamp,
    output logic             seen_now,
    output logic [CYC_W-1:0] stamp_now
);
    typedef struct packed {
        logic             seen;
        logic [CYC_W-1:0] stamp;
    } evt_t;

    evt_t evt_d, evt_q;

    always_comb begin
        evt_d = evt_q;
        if (clear) begin
            evt_d = '0;
        end else if (hit && !evt_q.seen) begin
            evt_d.seen  = 1'b1;
            evt_d.stamp = stamp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    // Includes an event arriving in the current cycle.
    assign seen_now  = evt_q.seen | hit;
    assign stamp_now = evt_q.seen ? evt_q.stamp : stamp;

    p_latch_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q.seen && !clear) |=> (evt_q.seen && $stable(evt_q.stamp)));

endmodule

// File: rtl/fom_verdict.sv
module fom_verdict
    import fom_pkg::*;
#(
    parameter int unsigned CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             finish,
    input  logic             exc_hit,
    input  logic             exc_berr,
    input  logic             store_diff,
    input  logic [CYC_W-1:0] det_cyc,
    input  logic             inj_seen,
    input  logic [CYC_W-1:0] inj_cyc,
    input  logic             dif_seen,
    input  logic [CYC_W-1:0] dif_cyc,
    output logic             res_valid,
    output logic [2:0]       res_class,
    output logic [1:0]       res_exc,
    output logic [CYC_W-1:0] res_latency,
    output logic             res_diff_seen,
    output logic [CYC_W-1:0] res_first_diff
);
    typedef struct packed {
        logic             valid;
        fom_class_e       cls;
        fom_exc_e         exc;
        logic [CYC_W-1:0] lat;
        logic             dseen;
        logic [CYC_W-1:0] dcyc;
    } vrd_t;

    vrd_t vrd_d, vrd_q;

    always_comb begin
        vrd_d       = vrd_q;
        vrd_d.valid = 1'b0;
        if (finish) begin
            vrd_d.valid = 1'b1;
            vrd_d.dseen = dif_seen;
            vrd_d.dcyc  = dif_seen ? dif_cyc : '0;
            vrd_d.lat   = '0;
            vrd_d.exc   = EXC_NONE;
            if (exc_hit) begin
                vrd_d.cls = CLS_HWDET;
                vrd_d.exc = exc_berr ? EXC_BERR : EXC_ILLEG;
                if (inj_seen) begin
                    vrd_d.lat = det_cyc - inj_cyc;
                end
            end else if (dif_seen) begin
                vrd_d.cls = CLS_BUSACT;
            end else if (store_diff) begin
                vrd_d.cls = CLS_LATENT;
            end else begin
                vrd_d.cls = CLS_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vrd_q <= '0;
        end else begin
            vrd_q <= vrd_d;
        end
    end

    assign res_valid      = vrd_q.valid;
    assign res_class      = vrd_q.cls;
    assign res_exc        = vrd_q.exc;
    assign res_latency    = vrd_q.lat;
    assign res_diff_seen  = vrd_q.dseen;
    assign res_first_diff = vrd_q.dcyc;

    p_quiet_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_class != CLS_HWDET) |-> (res_latency == '0 && res_exc == EXC_NONE));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> ($stable(res_class) && $stable(res_latency) && !res_valid));

endmodule

// File: rtl/fault_outcome_monitor.sv
module fault_outcome_monitor
    import fom_pkg::*;
#(
    parameter int unsigned BUS_W = 16,
    parameter int unsigned CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_start,
    input  logic             inj_pulse,
    input  logic             bus_cyc,
    input  logic [BUS_W-1:0] ref_bus,
    input  logic [BUS_W-1:0] obs_bus,
    input  logic             exc_berr,
    input  logic             exc_illeg,
    input  logic             run_end,
    input  logic             store_diff,
    output logic             run_active,
    output logic             res_valid,
    output logic [2:0]       res_class,
    output logic [1:0]       res_exc,
    output logic [CYC_W-1:0] res_latency,
    output logic             res_diff_seen,
    output logic [CYC_W-1:0] res_first_diff
);
    logic             live;
    logic             cyc_live;
    logic             exc_hit;
    logic             finish;
    logic [CYC_W-1:0] cyc_num;
    logic [FOM_NUM_EVT-1:0] ev_hit;
    logic [FOM_NUM_EVT-1:0] ev_seen;
    logic [CYC_W-1:0]       ev_stamp [FOM_NUM_EVT];

    // Events count only inside an active run and never in a restart cycle.
    assign live     = run_active & ~run_start;
    assign cyc_live = live & bus_cyc;
    assign exc_hit  = cyc_live & (exc_berr | exc_illeg);
    assign finish   = exc_hit | (live & run_end);

    assign ev_hit[FOM_EVT_INJ] = live & inj_pulse;
    assign ev_hit[FOM_EVT_DIF] = cyc_live & (ref_bus != obs_bus);

    fom_cycle_counter #(.CYC_W(CYC_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (run_start),
        .bus_cyc (bus_cyc),
        .finish  (finish),
        .active  (run_active),
        .count   (cyc_num)
    );

    for (genvar e = 0; e < FOM_NUM_EVT; e++) begin : g_evt
        fom_first_event #(.CYC_W(CYC_W)) u_evt (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (run_start),
            .hit       (ev_hit[e]),
            .stamp     (cyc_num),
            .seen_now  (ev_seen[e]),
            .stamp_now (ev_stamp[e])
        );
    end

    fom_verdict #(.CYC_W(CYC_W)) u_vrd (
        .clk            (clk),
        .rst_n          (rst_n),
        .finish         (finish),
        .exc_hit        (exc_hit),
        .exc_berr       (exc_berr),
        .store_diff     (store_diff),
        .det_cyc        (cyc_num),
        .inj_seen       (ev_seen[FOM_EVT_INJ]),
        .inj_cyc        (ev_stamp[FOM_EVT_INJ]),
        .dif_seen       (ev_seen[FOM_EVT_DIF]),
        .dif_cyc        (ev_stamp[FOM_EVT_DIF]),
        .res_valid      (res_valid),
        .res_class      (res_class),
        .res_exc        (res_exc),
        .res_latency    (res_latency),
        .res_diff_seen  (res_diff_seen),
        .res_first_diff (res_first_diff)
    );

    p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && !run_start && bus_cyc && (exc_berr || exc_illeg))
        |=> (!run_active && res_valid && res_class == CLS_HWDET));

    p_berr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && !run_start && bus_cyc && exc_berr) |=> (res_exc == EXC_BERR));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_active && !run_start) |=> !res_valid);

    p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && !run_start && !bus_cyc && !run_end) |=> (run_active && !res_valid));

endmodule

// File: tb/fault_outcome_monitor_bench.sv
module fault_outcome_monitor_bench;
    localparam int BUS_W = 8;
    localparam int CYC_W = 6;
    localparam int CMAX  = (1 << CYC_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_start = 1'b0;
    logic             inj_pulse = 1'b0;
    logic             bus_cyc = 1'b0;
    logic [BUS_W-1:0] ref_bus = '0;
    logic [BUS_W-1:0] obs_bus = '0;
    logic             exc_berr = 1'b0;
    logic             exc_illeg = 1'b0;
    logic             run_end = 1'b0;
    logic             store_diff = 1'b0;
    logic             run_active;
    logic             res_valid;
    logic [2:0]       res_class;
    logic [1:0]       res_exc;
    logic [CYC_W-1:0] res_latency;
    logic             res_diff_seen;
    logic [CYC_W-1:0] res_first_diff;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fault_outcome_monitor #(.BUS_W(BUS_W), .CYC_W(CYC_W)) u_fault_outcome_monitor (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .inj_pulse(inj_pulse),
        .bus_cyc(bus_cyc), .ref_bus(ref_bus), .obs_bus(obs_bus),
        .exc_berr(exc_berr), .exc_illeg(exc_illeg), .run_end(run_end),
        .store_diff(store_diff), .run_active(run_active), .res_valid(res_valid),
        .res_class(res_class), .res_exc(res_exc), .res_latency(res_latency),
        .res_diff_seen(res_diff_seen), .res_first_diff(res_first_diff)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        run_start = 0; inj_pulse = 0; bus_cyc = 0; exc_berr = 0;
        exc_illeg = 0; run_end = 0; store_diff = 0; ref_bus = '0; obs_bus = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_in();
    endtask

    task automatic start_run();
        run_start = 1;
        tick();
    endtask

    // One run: bus cycles 0..n-1, injection at inj_k, mismatches from dif_k on
    // (dif_k < 0: none), exception kind xk (bit0 invalid address, bit1 invalid
    // opcode) at cycle ev_k; without exception run_end follows with store flag st.
    task automatic run_case(input int inj_k, input int dif_k, input int ev_k,
                            input int xk, input int n, input bit st, input string tag);
        int  stray = 0;
        int  last;
        int  e_cls, e_exc, e_lat, e_ds, e_fd;
        start_run();
        last = (xk != 0) ? ev_k : n - 1;
        for (int c = 0; c <= last; c++) begin
            bus_cyc   = 1;
            ref_bus   = BUS_W'(c * 7 + 3);
            obs_bus   = ref_bus ^ ((dif_k >= 0 && c >= dif_k) ? BUS_W'(c + 1) : '0);
            inj_pulse = (c == inj_k);
            if (xk != 0 && c == ev_k) begin
                exc_berr  = xk[0];
                exc_illeg = xk[1];
                store_diff = st;
                run_end   = st;
            end
            tick();
            if (c != last || xk == 0) stray += int'(res_valid);
        end
        if (xk == 0) begin
            run_end = 1; store_diff = st;
            tick();
        end
        check({tag, " R11 no early verdict"}, stray, 0);
        check({tag, " R11 verdict pulse"}, int'(res_valid), 1);
        e_ds = (dif_k >= 0 && dif_k <= last) ? 1 : 0;
        e_fd = e_ds ? dif_k : 0;
        if (xk != 0) begin
            e_cls = 3;
            e_exc = xk[0] ? 1 : 2;
            e_lat = (inj_k <= ev_k) ? ev_k - inj_k : 0;
        end else begin
            e_exc = 0; e_lat = 0;
            e_cls = e_ds ? 2 : (st ? 1 : 0);
        end
        check({tag, " R3/R5/R6/R7 class"}, int'(res_class), e_cls);
        check({tag, " R3 exception kind"}, int'(res_exc), e_exc);
        check({tag, " R4 latency"}, int'(res_latency), e_lat);
        check({tag, " R8 diff seen"}, int'(res_diff_seen), e_ds);
        check({tag, " R2 R8 R9 first diff cycle"}, int'(res_first_diff), e_fd);
        tick();
        check({tag, " R11 pulse width"}, int'(res_valid), 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_in();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(res_valid), 0);
        check("R1 class", int'(res_class), 0);
        check("R1 exc", int'(res_exc), 0);
        check("R1 active", int'(run_active), 0);
        rst_n = 1;
        tick();
        // R11 run_end with no active run
        run_end = 1; store_diff = 1;
        tick();
        check("R11 idle run_end", int'(res_valid), 0);

        // Sweep of exception runs (R3, R4, R9)
        for (int inj = 0; inj < 4; inj++)
            for (int ev = 0; ev < 8; ev++)
                for (int xk = 1; xk < 4; xk++)
                    for (int d = 0; d < 4; d++)
                        run_case(inj, (d == 0) ? -1 : (d == 1 ? ev : d * 2 - 2),
                                 ev, xk, 0, d[0], "exc");

        // Sweep of non-exception runs (R5, R6, R7, R8)
        for (int d = -1; d < 6; d++)
            for (int st = 0; st < 2; st++)
                run_case(1, d, 0, 0, 6, st[0], "end");

        // R10: flags and mismatches outside a bus cycle are ignored
        start_run();
        exc_berr = 1; exc_illeg = 1; ref_bus = 8'h11; obs_bus = 8'h22;
        tick();
        check("R10 still active", int'(run_active), 1);
        check("R10 no verdict", int'(res_valid), 0);
        run_end = 1;
        tick();
        check("R10 class none", int'(res_class), 0);
        check("R10 no diff", int'(res_diff_seen), 0);

        // R3: after a halt, further inputs change nothing
        run_case(0, -1, 2, 2, 0, 1'b0, "halt");
        bus_cyc = 1; exc_berr = 1; ref_bus = 8'h01; obs_bus = 8'h02;
        tick();
        run_end = 1; store_diff = 1;
        tick();
        check("R3 ignored after halt valid", int'(res_valid), 0);
        check("R3 ignored after halt class", int'(res_class), 3);
        check("R3 ignored after halt exc", int'(res_exc), 2);
        check("R3 ignored after halt active", int'(run_active), 0);

        // R12: saturation of the cycle number
        start_run();
        for (int c = 0; c < 70; c++) begin
            bus_cyc = 1; inj_pulse = (c == 0);
            ref_bus = 8'h5A; obs_bus = (c == 66) ? 8'hA5 : 8'h5A;
            tick();
        end
        bus_cyc = 1; exc_illeg = 1;
        tick();
        check("R12 saturated latency", int'(res_latency), CMAX);
        check("R12 saturated first diff", int'(res_first_diff), CMAX);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule